// File: doc/BRIEF.md
# Filtered Temperature-Indexed Code Selector

This block sits between a temperature converter and a current-output DAC. Each conversion arrives as an 8-bit byte with a one-cycle valid strobe, where 0x00 is the coldest reading and 0xFF the hottest. A stability filter decides which conversions reach the readable status byte. The upper six bits of the status byte pick a row of a 64-entry byte table, and the selected byte drives the DAC.

Two select inputs can bypass parts of this path. One replaces the converter-derived row with a 6-bit row supplied by a register. The other replaces the table output with an 8-bit code supplied by a register. The output direction bit and the 2-bit full-scale field are passed straight through to the DAC.

After reset the DAC code stays at zero until the filter accepts its first conversion. The table is a synchronous memory model. It is loaded through a byte-addressed write port whose window starts at 0x90.

Top module: `tcs_code_selector`

## Requirements
- R1: While reset is asserted and directly after it, `status_byte` is 0x00, `dac_code` is 0x00 and `tbl_addr` is 0x90.
- R2: With `filter_off` = 0, `status_byte` takes the full conversion byte only on the fourth of four consecutive strobed conversions whose bits 7..2 are equal. It is visible after the clock edge that samples that fourth strobe. Once four have matched, each further matching conversion also updates the status.
- R3: A strobed conversion whose bits 7..2 differ from those of the previous strobed conversion restarts the run count at one and leaves `status_byte` unchanged while `filter_off` = 0.
- R4: With `filter_off` = 1, every strobed conversion is copied into `status_byte` at the sampling edge. Conversions strobed in this mode still count toward the run.
- R5: `tbl_addr` equals 0x90 plus the row. The row is `status_byte[7:2]` when `row_direct` = 0 and `row_reg` when `row_direct` = 1. The address therefore always lies in 0x90..0xCF, and a status of 0xFF maps to 0xCF.
- R6: With `code_direct` = 0, `dac_code` equals the table byte at the selected row two clock edges after the row is presented. This includes a change of `row_direct` or `row_reg`.
- R7: With `code_direct` = 1, `dac_code` equals `code_reg` one edge later, and `row_direct` and `row_reg` have no effect on it.
- R8: After reset, `dac_code` is 0x00 until the filter accepts a conversion. At the accepting edge and at the next edge it is still 0x00. It takes the selected value at the second edge after the accepting edge.
- R9: `dac_sink` follows `sink_mode` (0 = source, 1 = sink) and `dac_fs` follows `fs_code` combinationally. The value 00 is reserved and is passed through unchanged.
- R10: Conversion strobes that occur while reset is asserted neither update the status nor count toward the run of four.
- R11: A table write stores `tbl_wr_data` into row `tbl_wr_addr` − 0x90 only when `tbl_wr_addr` is in 0x90..0xCF. Writes outside that window leave every row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | Conversion strobe, one cycle per result |
| conv_data | input | 8 | Conversion result, 0x00 coldest, 0xFF hottest |
| filter_off | input | 1 | 1: accept every conversion; 0: require four matching |
| row_direct | input | 1 | 1: table row comes from `row_reg` |
| row_reg | input | 6 | Register-supplied table row |
| code_direct | input | 1 | 1: DAC code comes from `code_reg` |
| code_reg | input | 8 | Register-supplied DAC code |
| sink_mode | input | 1 | Output direction, 0 source, 1 sink |
| fs_code | input | 2 | Full-scale range select |
| tbl_wr_en | input | 1 | Table write enable |
| tbl_wr_addr | input | 8 | Table write byte address |
| tbl_wr_data | input | 8 | Table write data |
| status_byte | output | 8 | Last accepted conversion |
| tbl_addr | output | 8 | Byte address of the selected table row |
| dac_code | output | 8 | Code driving the DAC |
| dac_sink | output | 1 | Direction passed to the DAC |
| dac_fs | output | 2 | Full-scale range passed to the DAC |

## Verification
The bench first sends strobes while reset is held. It then checks that three matching conversions after release are not enough. A design that counted the reset-time strobes would update the status one conversion early.

It interleaves runs that break on bits 7..2 with runs that differ only in bits 1..0. A filter that compared the whole byte, or failed to restart its count, would accept at the wrong conversion. It also checks that conversions accepted in pass-through mode still count toward the run.

The zero-hold after reset is checked edge by edge. A design that drops the hold one edge early would show the stale row-0 byte.

Out-of-window table writes at 0x8F and 0xD0 are checked at rows 63 and 0. A design that truncated the address would alias those writes into the table. Toggling the row selects while the direct code is active shows whether the row path leaks into the output.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   // source chosen for the registered DAC code
   typedef enum logic [1:0] {
      SRC_ZERO  = 2'd0,
      SRC_TABLE = 2'd1,
      SRC_REG   = 2'd2
   } code_src_e;

   function automatic code_src_e pick_source(input logic live, input logic direct);
      if (!live)
         return SRC_ZERO;
      else if (direct)
         return SRC_REG;
      else
         return SRC_TABLE;
   endfunction

endpackage

// File: rtl/tcs_accept_filter.sv
module tcs_accept_filter #(
   parameter int DATA_W  = 8,
   parameter int MATCH_W = 6,
   parameter int RUN_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              filter_off,
   output logic [DATA_W-1:0] status_q,
   output logic              accepted_q
);
   localparam int CNT_W = $clog2(RUN_LEN + 1);

   initial begin
      assert (RUN_LEN >= 1) else $error("RUN_LEN must be at least 1");
      assert (MATCH_W >= 1 && MATCH_W <= DATA_W) else $error("MATCH_W out of range");
   end

   logic [MATCH_W-1:0] upper_in;
   logic [MATCH_W-1:0] prev_q;
   logic               have_prev_q;
   logic               same_upper;
   logic               run_full;
   logic               take;

   assign upper_in   = conv_data[DATA_W-1 -: MATCH_W];
   assign same_upper = have_prev_q && (upper_in == prev_q);

   generate
      if (RUN_LEN == 1) begin : g_single
         assign run_full = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] run_q;
         logic [CNT_W-1:0] run_nx;

         always_comb begin
            if (!same_upper)
               run_nx = CNT_W'(1);
            else if (run_q == CNT_W'(RUN_LEN))
               run_nx = run_q;
            else
               run_nx = run_q + CNT_W'(1);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (conv_valid)
               run_q <= run_nx;
         end

         assign run_full = (run_nx == CNT_W'(RUN_LEN));
      end
   endgenerate

   assign take = conv_valid && (filter_off || run_full);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q      <= '0;
         have_prev_q <= 1'b0;
         status_q    <= '0;
         accepted_q  <= 1'b0;
      end else begin
         if (conv_valid) begin
            prev_q      <= upper_in;
            have_prev_q <= 1'b1;
         end
         if (take) begin
            status_q   <= conv_data;
            accepted_q <= 1'b1;
         end
      end
   end

   // R4: pass-through mode copies each strobed byte
   a_r4_bypass_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_valid && filter_off) |=> (status_q == $past(conv_data)));

   // R2: no strobe, no status change
   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_valid |=> $stable(status_q));

   // R3: a break in the upper bits never updates the status while filtering
   a_r3_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((RUN_LEN > 1) && conv_valid && !filter_off && have_prev_q && (upper_in != prev_q))
      |=> $stable(status_q));

endmodule

// File: rtl/tcs_row_addr.sv
module tcs_row_addr #(
   parameter int          ROW_W  = 6,
   parameter int          ADDR_W = 8,
   parameter logic [31:0] BASE   = 32'h90
) (
   input  logic [ROW_W-1:0]  status_row,
   input  logic [ROW_W-1:0]  reg_row,
   input  logic              row_direct,
   output logic [ROW_W-1:0]  row,
   output logic [ADDR_W-1:0] byte_addr
);
   initial begin
      assert (BASE + (1 << ROW_W) - 1 < (1 << ADDR_W))
         else $error("table window does not fit the address width");
   end

   assign row       = row_direct ? reg_row : status_row;
   assign byte_addr = ADDR_W'(BASE) + ADDR_W'(row);

endmodule

// File: rtl/tcs_code_table.sv
module tcs_code_table #(
   parameter int          DATA_W = 8,
   parameter int          ROW_W  = 6,
   parameter int          ADDR_W = 8,
   parameter logic [31:0] BASE   = 32'h90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_q
);
   localparam int ROWS = 1 << ROW_W;
   localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + ROWS - 1);

   logic [DATA_W-1:0] mem [ROWS];
   logic              wr_hit;

   assign wr_hit = wr_en && (wr_addr >= LO) && (wr_addr <= HI);

   always_ff @(posedge clk) begin
      if (wr_hit)
         mem[ROW_W'(wr_addr - LO)] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else
         rd_q <= mem[rd_row];
   end

endmodule

// File: rtl/tcs_code_mux.sv
module tcs_code_mux
   import tcs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accepted,
   input  logic              code_direct,
   input  logic [DATA_W-1:0] code_reg,
   input  logic [DATA_W-1:0] tbl_byte,
   output logic [DATA_W-1:0] dac_q
);
   logic      live_q;
   code_src_e src;

   assign src = pick_source(live_q, code_direct);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         dac_q  <= '0;
      end else begin
         live_q <= accepted;
         unique case (src)
            SRC_TABLE: dac_q <= tbl_byte;
            SRC_REG:   dac_q <= code_reg;
            default:   dac_q <= '0;
         endcase
      end
   end

   // R7: direct code reaches the output one edge later
   a_r7_direct_code: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && code_direct) |=> (dac_q == $past(code_reg)));

   // R6: table byte reaches the output one edge after the read
   a_r6_table_path: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && !code_direct) |=> (dac_q == $past(tbl_byte)));

endmodule

// File: rtl/tcs_code_selector.sv
module tcs_code_selector #(
   parameter int          DATA_W   = 8,
   parameter int          ROW_W    = 6,
   parameter int          ADDR_W   = 8,
   parameter int          RUN_LEN  = 4,
   parameter int          FS_W     = 2,
   parameter logic [31:0] TBL_BASE = 32'h90
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              filter_off,
   input  logic              row_direct,
   input  logic [ROW_W-1:0]  row_reg,
   input  logic              code_direct,
   input  logic [DATA_W-1:0] code_reg,
   input  logic              sink_mode,
   input  logic [FS_W-1:0]   fs_code,
   input  logic              tbl_wr_en,
   input  logic [ADDR_W-1:0] tbl_wr_addr,
   input  logic [DATA_W-1:0] tbl_wr_data,
   output logic [DATA_W-1:0] status_byte,
   output logic [ADDR_W-1:0] tbl_addr,
   output logic [DATA_W-1:0] dac_code,
   output logic              dac_sink,
   output logic [FS_W-1:0]   dac_fs
);
   localparam int ROWS = 1 << ROW_W;

   logic              accepted;
   logic [ROW_W-1:0]  row;
   logic [DATA_W-1:0] tbl_byte;

   tcs_accept_filter #(
      .DATA_W (DATA_W),
      .MATCH_W(ROW_W),
      .RUN_LEN(RUN_LEN)
   ) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_valid(conv_valid),
      .conv_data (conv_data),
      .filter_off(filter_off),
      .status_q  (status_byte),
      .accepted_q(accepted)
   );

   tcs_row_addr #(
      .ROW_W (ROW_W),
      .ADDR_W(ADDR_W),
      .BASE  (TBL_BASE)
   ) u_row (
      .status_row(status_byte[DATA_W-1 -: ROW_W]),
      .reg_row   (row_reg),
      .row_direct(row_direct),
      .row       (row),
      .byte_addr (tbl_addr)
   );

   tcs_code_table #(
      .DATA_W(DATA_W),
      .ROW_W (ROW_W),
      .ADDR_W(ADDR_W),
      .BASE  (TBL_BASE)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr_en),
      .wr_addr(tbl_wr_addr),
      .wr_data(tbl_wr_data),
      .rd_row (row),
      .rd_q   (tbl_byte)
   );

   tcs_code_mux #(
      .DATA_W(DATA_W)
   ) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .accepted   (accepted),
      .code_direct(code_direct),
      .code_reg   (code_reg),
      .tbl_byte   (tbl_byte),
      .dac_q      (dac_code)
   );

   assign dac_sink = sink_mode;
   assign dac_fs   = fs_code;

   // R5: selected address stays in the table window
   a_r5_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_addr >= ADDR_W'(TBL_BASE)) && (tbl_addr <= ADDR_W'(TBL_BASE + ROWS - 1)));

   // R8: no accepted conversion yet means a zero code two edges on
   a_r8_zero_before_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !accepted |-> ##2 (dac_code == '0));

endmodule

// File: tb/tcs_code_selector_bench.sv
module tcs_code_selector_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_valid = 1'b0;
   logic [7:0] conv_data = 8'h00;
   logic       filter_off = 1'b0;
   logic       row_direct = 1'b0;
   logic [5:0] row_reg = 6'h00;
   logic       code_direct = 1'b0;
   logic [7:0] code_reg = 8'h00;
   logic       sink_mode = 1'b0;
   logic [1:0] fs_code = 2'b11;
   logic       tbl_wr_en = 1'b0;
   logic [7:0] tbl_wr_addr = 8'h00;
   logic [7:0] tbl_wr_data = 8'h00;
   logic [7:0] status_byte;
   logic [7:0] tbl_addr;
   logic [7:0] dac_code;
   logic       dac_sink;
   logic [1:0] dac_fs;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tcs_code_selector u_tcs_code_selector (
      .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_data(conv_data),
      .filter_off(filter_off), .row_direct(row_direct), .row_reg(row_reg),
      .code_direct(code_direct), .code_reg(code_reg), .sink_mode(sink_mode),
      .fs_code(fs_code), .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
      .tbl_wr_data(tbl_wr_data), .status_byte(status_byte), .tbl_addr(tbl_addr),
      .dac_code(dac_code), .dac_sink(dac_sink), .dac_fs(dac_fs)
   );

   // {kind, filter_off, conv_data, expected status}
   // kind 0 = R2, 1 = R3, 2 = R4, 3 = R10
   localparam logic [18:0] VECS [17] = '{
      {2'd3, 1'b0, 8'hA4, 8'h00},
      {2'd3, 1'b0, 8'hA5, 8'h00},
      {2'd3, 1'b0, 8'hA6, 8'h00},
      {2'd0, 1'b0, 8'hA7, 8'hA7},
      {2'd1, 1'b0, 8'hA8, 8'hA7},
      {2'd1, 1'b0, 8'hA8, 8'hA7},
      {2'd1, 1'b0, 8'hA4, 8'hA7},
      {2'd1, 1'b0, 8'hA8, 8'hA7},
      {2'd1, 1'b0, 8'hA9, 8'hA7},
      {2'd1, 1'b0, 8'hAA, 8'hA7},
      {2'd0, 1'b0, 8'hAB, 8'hAB},
      {2'd0, 1'b0, 8'hA8, 8'hA8},
      {2'd2, 1'b1, 8'h13, 8'h13},
      {2'd2, 1'b1, 8'hF0, 8'hF0},
      {2'd0, 1'b0, 8'hF1, 8'hF0},
      {2'd0, 1'b0, 8'hF2, 8'hF0},
      {2'd0, 1'b0, 8'hF3, 8'hF3}
   };

   function automatic string tag(input logic [1:0] k);
      case (k)
         2'd0:    return "R2";
         2'd1:    return "R3";
         2'd2:    return "R4";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [7:0] tval(input int r);
      return 8'((r * 37 + 11) & 255);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic twrite(input logic [7:0] a, input logic [7:0] d);
      tbl_wr_en   = 1'b1;
      tbl_wr_addr = a;
      tbl_wr_data = d;
      tick(1);
      tbl_wr_en = 1'b0;
   endtask

   initial begin
      // R10 / R1: strobes while reset is held
      conv_valid = 1'b1;
      conv_data  = 8'hA4;
      tick(3);
      chk("R1 status in reset", status_byte, 8'h00);
      chk("R1 dac in reset", dac_code, 8'h00);
      chk("R1 addr in reset", tbl_addr, 8'h90);
      conv_valid = 1'b0;
      rst_n = 1'b1;
      tick(1);
      chk("R1 status after reset", status_byte, 8'h00);

      // R11: load table, then try writes outside the window
      for (int r = 0; r < 64; r++) twrite(8'(8'h90 + r), tval(r));
      twrite(8'h8F, 8'hEE);
      twrite(8'hD0, 8'hDD);
      chk("R8 dac before any accept", dac_code, 8'h00);

      // table-driven filter walk (R2 R3 R4 R10)
      for (int i = 0; i < 17; i++) begin
         conv_valid = 1'b1;
         filter_off = VECS[i][16];
         conv_data  = VECS[i][15:8];
         tick(1);
         chk(tag(VECS[i][18:17]), status_byte, VECS[i][7:0]);
      end
      conv_valid = 1'b0;
      filter_off = 1'b0;
      chk("R5 addr from status F3", tbl_addr, 8'hCC);
      tick(2);
      chk("R6 dac from row 60", dac_code, tval(60));

      // R8: zero hold, edge by edge, after a fresh reset
      rst_n = 1'b0;
      tick(1);
      rst_n = 1'b1;
      tick(1);
      filter_off = 1'b1;
      conv_valid = 1'b1;
      conv_data  = 8'hFF;
      tick(1);
      conv_valid = 1'b0;
      chk("R8 status accepted", status_byte, 8'hFF);
      chk("R8 dac at accept edge", dac_code, 8'h00);
      chk("R5 hottest maps to CF", tbl_addr, 8'hCF);
      tick(1);
      chk("R8 dac one edge later", dac_code, 8'h00);
      tick(1);
      chk("R8 dac two edges later", dac_code, tval(63));
      chk("R11 row 63 kept", dac_code, tval(63));

      // coldest reading
      conv_valid = 1'b1;
      conv_data  = 8'h00;
      tick(1);
      conv_valid = 1'b0;
      chk("R5 coldest maps to 90", tbl_addr, 8'h90);
      tick(2);
      chk("R11 row 0 kept", dac_code, tval(0));

      // R5 / R6: register row
      row_direct = 1'b1;
      row_reg    = 6'h15;
      #1;
      chk("R5 register row addr", tbl_addr, 8'hA5);
      tick(2);
      chk("R6 register row dac", dac_code, tval(21));

      // R7: direct code, row selects ignored
      code_direct = 1'b1;
      code_reg    = 8'h5C;
      tick(2);
      chk("R7 direct code", dac_code, 8'h5C);
      row_direct = 1'b0;
      row_reg    = 6'h3E;
      tick(2);
      chk("R7 row select ignored", dac_code, 8'h5C);
      row_direct = 1'b1;
      tick(2);
      chk("R7 row reg ignored", dac_code, 8'h5C);
      code_direct = 1'b0;
      tick(2);
      chk("R6 back to table row 62", dac_code, tval(62));

      // R9: pass-through of direction and range
      sink_mode = 1'b1;
      fs_code   = 2'b01;
      #1;
      chk("R9 sink", {7'd0, dac_sink}, 8'h01);
      chk("R9 range 01", {6'd0, dac_fs}, 8'h01);
      sink_mode = 1'b0;
      fs_code   = 2'b00;
      #1;
      chk("R9 source", {7'd0, dac_sink}, 8'h00);
      chk("R9 reserved range", {6'd0, dac_fs}, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule